// File: doc/BRIEF.md
# Windowed Signal Power Monitor

This block watches a stream of 14-bit two's-complement samples and measures it over a window whose length is set in clock cycles. One sample is taken on every clock edge while the monitor is enabled. Control inputs choose which quantity is reported for each window. The choices are the mean-square power, the root-mean-square power, the largest magnitude seen, or the number of samples whose magnitude reaches a threshold. A complex option treats channel A as I and channel B as Q, so that each sample contributes I² + Q² to the power.

At the end of every window the selected result is written into its output register and a one-cycle valid strobe is raised. A downstream serial formatter can pick up the result on that strobe. The other two result registers keep their previous contents. The root-mean-square result comes from a bit-serial square root that starts when the window closes, so its strobe arrives a fixed number of cycles later than the other results.

Top module: `sig_power_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `pwr_out`, `peak_out` and `xcnt_out` are zero and `res_valid` is low until the first window completes.
- R2: A window holds max(`win_len`, 128) samples, so programmed lengths below 128 are raised to 128. For mean-square, peak and crossing results, `res_valid` is seen high in the cycle right after the clock edge that takes the window's last sample.
- R3: With `mode_sel` = 2'b00 and `ms_sel` = 1, `pwr_out` is the window's sum of per-sample powers. When the window length is a power of two, the sum is first divided by that length (a right shift). If the value does not fit in 20 bits, `pwr_out` saturates at 1048575.
- R4: With `mode_sel` = 2'b00 and `ms_sel` = 0, `pwr_out` is the floor of the square root of the mean value (before the 20-bit saturation). Its strobe comes 15 cycles later than the mean-square strobe for the same window would.
- R5: With `cplx_en` = 1 the power of each sample is a² + b². With `cplx_en` = 0 it is a², and `samp_b` has no effect on any result.
- R6: With `mode_sel` = 2'b01, `peak_out` is the largest |a| in the window. A magnitude above 8191 (the sample -8192) is reported as 8191.
- R7: With `mode_sel` = 2'b10 or 2'b11, `xcnt_out` counts the samples of the window whose magnitude (saturated as in R6) is greater than or equal to `thresh`. The count stops at 8191.
- R8: While `mon_en` is low, no strobe is produced and all outputs hold. The first sample taken after enabling is the one present on the enabling cycle.
- R9: A change of `mode_sel` or `cplx_en` while enabled discards the partial window. A new window starts with the sample present on the cycle of the change.
- R10: Only the output that belongs to the selected mode is updated at a window end. Outputs never change in a cycle without a strobe.
- R11: `res_valid` is high for exactly one cycle per completed window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_en | input | 1 | Monitor enable |
| mode_sel | input | 2 | Result select: 00 power, 01 peak, 1x crossing count |
| ms_sel | input | 1 | Power flavour: 1 mean-square, 0 root-mean-square |
| cplx_en | input | 1 | Take channel A as I and channel B as Q |
| win_len | input | 24 | Window length in cycles (raised to 128 minimum) |
| thresh | input | 13 | Magnitude threshold for crossing counts |
| samp_a | input | 14 | Channel A sample, two's complement |
| samp_b | input | 14 | Channel B sample, two's complement |
| pwr_out | output | 20 | Latched power result |
| peak_out | output | 13 | Latched peak magnitude |
| xcnt_out | output | 13 | Latched crossing count |
| res_valid | output | 1 | One-cycle strobe when a result is latched |

## Verification
The power path is driven with an alternating ±A square wave, with and without a single large spike. The plain square wave gives the same mean for any window length. The spike only averages to the expected value if the shift matches the window length, and it yields a non-square mean that checks the floor behaviour of the square root. Window lengths of 128, 200, 256 and 10 separate the shift path from the raw-sum path and show the minimum-length rule. Channel B is set to a different amplitude in real mode to show that it is ignored. Peak and crossing modes use spikes above and below the threshold and the sample -8192 to reach the saturation limits. Directed runs put a large value into a partial window and then change the mode or the complex bit, and confirm that the value does not reach the following result.

// File: rtl/spm_pkg.sv
package spm_pkg;

   // Result selection; both upper codes select crossing counts.
   typedef enum logic [1:0] {
      SPM_POWER    = 2'b00,
      SPM_PEAK     = 2'b01,
      SPM_XING     = 2'b10,
      SPM_XING_ALT = 2'b11
   } spm_mode_e;

endpackage

// File: rtl/spm_sample_prep.sv
// Per-sample arithmetic: power contribution and saturated magnitude.
module spm_sample_prep #(
   parameter int DATA_W = 14,
   parameter int PEAK_W = 13
) (
   input  logic [DATA_W-1:0]   samp_a,
   input  logic [DATA_W-1:0]   samp_b,
   input  logic                cplx_en,
   output logic [2*DATA_W-1:0] pwr,
   output logic [PEAK_W-1:0]   mag_a
);
   localparam int SQ_W = 2 * DATA_W;

   logic [DATA_W-1:0] abs_a, abs_b;
   logic [SQ_W-1:0]   sq_a, sq_b;

   always_comb begin
      abs_a = samp_a[DATA_W-1] ? (~samp_a + 1'b1) : samp_a;
      abs_b = samp_b[DATA_W-1] ? (~samp_b + 1'b1) : samp_b;
      sq_a  = {{DATA_W{1'b0}}, abs_a} * {{DATA_W{1'b0}}, abs_a};
      sq_b  = {{DATA_W{1'b0}}, abs_b} * {{DATA_W{1'b0}}, abs_b};
      pwr   = sq_a + (cplx_en ? sq_b : '0);
   end

   generate
      if (PEAK_W < DATA_W) begin : g_mag_sat
         assign mag_a = (|abs_a[DATA_W-1:PEAK_W]) ? '1 : abs_a[PEAK_W-1:0];
      end else begin : g_mag_full
         assign mag_a = abs_a;
      end
   endgenerate

endmodule

// File: rtl/spm_window.sv
// Window sequencing and running accumulation of sum, peak and crossings.
module spm_window #(
   parameter int PERIOD_W   = 24,
   parameter int MIN_PERIOD = 128,
   parameter int SQ_W       = 28,
   parameter int PEAK_W     = 13
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         restart,
   input  logic [PERIOD_W-1:0]          win_len,
   input  logic [PEAK_W-1:0]            thresh,
   input  logic [SQ_W-1:0]              pwr,
   input  logic [PEAK_W-1:0]            mag,
   output logic                         win_end,
   output logic [SQ_W+PERIOD_W-1:0]     tot_sum,
   output logic [PEAK_W-1:0]            tot_peak,
   output logic [PEAK_W-1:0]            tot_xcnt,
   output logic                         is_p2,
   output logic [$clog2(PERIOD_W)-1:0]  sh_amt
);
   localparam int ACC_W = SQ_W + PERIOD_W;
   localparam int SH_W  = $clog2(PERIOD_W);
   localparam logic [PERIOD_W-1:0] MIN_L = PERIOD_W'(MIN_PERIOD);

   logic [PERIOD_W-1:0] cnt_q, eff;
   logic [ACC_W-1:0]    acc_q;
   logic [PEAK_W-1:0]   peak_q, xcnt_q, x_base;
   logic                hit;

   always_comb begin
      eff   = (win_len < MIN_L) ? MIN_L : win_len;
      is_p2 = ~|(eff & (eff - 1'b1));
      sh_amt = '0;
      for (int i = 0; i < PERIOD_W; i++) begin
         if (eff[i]) sh_amt = SH_W'(i);
      end
   end

   always_comb begin
      hit      = (mag >= thresh);
      tot_sum  = restart ? ACC_W'(pwr) : acc_q + ACC_W'(pwr);
      tot_peak = (restart || mag > peak_q) ? mag : peak_q;
      x_base   = restart ? '0 : xcnt_q;
      tot_xcnt = (hit && x_base != '1) ? x_base + 1'b1 : x_base;
      win_end  = en && !restart && (cnt_q >= eff - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         peak_q <= '0;
         xcnt_q <= '0;
      end else if (!en || win_end) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         peak_q <= '0;
         xcnt_q <= '0;
      end else begin
         cnt_q  <= restart ? PERIOD_W'(1) : cnt_q + 1'b1;
         acc_q  <= tot_sum;
         peak_q <= tot_peak;
         xcnt_q <= tot_xcnt;
      end
   end

   // R2
   win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (cnt_q == '0));

   // R7
   xcnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !restart && !win_end && xcnt_q == '1) |=> (xcnt_q == '1));

endmodule

// File: rtl/spm_isqrt.sv
// Bit-serial non-restoring integer square root, one root bit per cycle.
module spm_isqrt #(
   parameter int ROOT_W = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                abort,
   input  logic [2*ROOT_W-1:0] op,
   output logic                done,
   output logic [ROOT_W-1:0]   root
);
   localparam int OP_W  = 2 * ROOT_W;
   localparam int REM_W = ROOT_W + 4;
   localparam int ST_W  = $clog2(ROOT_W);

   logic                    busy_q, done_q;
   logic [ST_W-1:0]         step_q;
   logic [OP_W-1:0]         op_q;
   logic signed [REM_W-1:0] rem_q, r_sh, r_nx, t_sub, t_add;
   logic [ROOT_W-1:0]       root_q, root_nx;
   logic [1:0]              pair;

   always_comb begin
      pair    = op_q[{step_q, 1'b0} +: 2];
      r_sh    = {rem_q[REM_W-3:0], pair};
      t_sub   = {{(REM_W-ROOT_W-2){1'b0}}, root_q, 2'b01};
      t_add   = {{(REM_W-ROOT_W-2){1'b0}}, root_q, 2'b11};
      r_nx    = rem_q[REM_W-1] ? (r_sh + t_add) : (r_sh - t_sub);
      root_nx = {root_q[ROOT_W-2:0], ~r_nx[REM_W-1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         step_q <= '0;
         op_q   <= '0;
         rem_q  <= '0;
         root_q <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         step_q <= ST_W'(ROOT_W - 1);
         op_q   <= op;
         rem_q  <= '0;
         root_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            rem_q  <= r_nx;
            root_q <= root_nx;
            if (step_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               step_q <= step_q - 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign root = root_q;

   logic [OP_W+1:0] r_ext, sq_lo, sq_hi;
   always_comb begin
      r_ext = (OP_W+2)'(root_q);
      sq_lo = r_ext * r_ext;
      sq_hi = (r_ext + 1'b1) * (r_ext + 1'b1);
   end

   // R4
   root_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (sq_lo <= {2'b00, op_q}) && (sq_hi > {2'b00, op_q}));

endmodule

// File: rtl/sig_power_monitor.sv
module sig_power_monitor #(
   parameter int DATA_W     = 14,
   parameter int PERIOD_W   = 24,
   parameter int MIN_PERIOD = 128,
   parameter int PWR_W      = 20,
   parameter int PEAK_W     = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mon_en,
   input  logic [1:0]          mode_sel,
   input  logic                ms_sel,
   input  logic                cplx_en,
   input  logic [PERIOD_W-1:0] win_len,
   input  logic [PEAK_W-1:0]   thresh,
   input  logic [DATA_W-1:0]   samp_a,
   input  logic [DATA_W-1:0]   samp_b,
   output logic [PWR_W-1:0]    pwr_out,
   output logic [PEAK_W-1:0]   peak_out,
   output logic [PEAK_W-1:0]   xcnt_out,
   output logic                res_valid
);
   import spm_pkg::*;

   localparam int SQ_W   = 2 * DATA_W;
   localparam int ROOT_W = DATA_W;
   localparam int ACC_W  = SQ_W + PERIOD_W;
   localparam int SH_W   = $clog2(PERIOD_W);

   generate
      if (PEAK_W > DATA_W) begin : g_bad_peak
         $error("PEAK_W must not exceed DATA_W");
      end
      if (PWR_W < ROOT_W) begin : g_bad_pwr
         $error("PWR_W must hold the square root");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (MIN_PERIOD <= ROOT_W + 2) begin : g_bad_min
         $error("MIN_PERIOD too short for the serial square root");
      end
      if (PERIOD_W > 31 || MIN_PERIOD >= (1 << PERIOD_W)) begin : g_bad_per
         $error("MIN_PERIOD must fit in PERIOD_W");
      end
   endgenerate

   spm_mode_e cur_mode;
   logic [1:0] mode_q;
   logic       en_q, cplx_q, restart;

   assign cur_mode = spm_mode_e'(mode_sel);
   assign restart  = mon_en && (!en_q || mode_q != mode_sel || cplx_q != cplx_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= '0;
         cplx_q <= 1'b0;
      end else begin
         en_q   <= mon_en;
         mode_q <= mode_sel;
         cplx_q <= cplx_en;
      end
   end

   logic [SQ_W-1:0]   s_pwr;
   logic [PEAK_W-1:0] s_mag;

   spm_sample_prep #(.DATA_W(DATA_W), .PEAK_W(PEAK_W)) u_prep (
      .samp_a (samp_a),
      .samp_b (samp_b),
      .cplx_en(cplx_en),
      .pwr    (s_pwr),
      .mag_a  (s_mag)
   );

   logic              win_end, is_p2;
   logic [ACC_W-1:0]  tot_sum;
   logic [PEAK_W-1:0] tot_peak, tot_xcnt;
   logic [SH_W-1:0]   sh_amt;

   spm_window #(
      .PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD), .SQ_W(SQ_W), .PEAK_W(PEAK_W)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mon_en),
      .restart (restart),
      .win_len (win_len),
      .thresh  (thresh),
      .pwr     (s_pwr),
      .mag     (s_mag),
      .win_end (win_end),
      .tot_sum (tot_sum),
      .tot_peak(tot_peak),
      .tot_xcnt(tot_xcnt),
      .is_p2   (is_p2),
      .sh_amt  (sh_amt)
   );

   // Mean value: scaled sum, clipped to the per-sample power width.
   logic [ACC_W-1:0] mean_full;
   logic [SQ_W-1:0]  mean_v;
   logic [PWR_W-1:0] ms_out;

   always_comb begin
      mean_full = is_p2 ? (tot_sum >> sh_amt) : tot_sum;
      mean_v    = (|mean_full[ACC_W-1:SQ_W]) ? '1 : mean_full[SQ_W-1:0];
   end

   generate
      if (PWR_W < SQ_W) begin : g_ms_sat
         assign ms_out = (|mean_v[SQ_W-1:PWR_W]) ? '1 : mean_v[PWR_W-1:0];
      end else begin : g_ms_ext
         assign ms_out = PWR_W'(mean_v);
      end
   endgenerate

   logic              sq_start, sq_abort, sq_done;
   logic [ROOT_W-1:0] sq_root;

   assign sq_start = win_end && (cur_mode == SPM_POWER) && !ms_sel;
   assign sq_abort = !mon_en || restart;

   spm_isqrt #(.ROOT_W(ROOT_W)) u_sqrt (
      .clk  (clk),
      .rst_n(rst_n),
      .start(sq_start),
      .abort(sq_abort),
      .op   (mean_v),
      .done (sq_done),
      .root (sq_root)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_out   <= '0;
         peak_out  <= '0;
         xcnt_out  <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         if (win_end) begin
            case (cur_mode)
               SPM_POWER: begin
                  if (ms_sel) begin
                     pwr_out   <= ms_out;
                     res_valid <= 1'b1;
                  end
               end
               SPM_PEAK: begin
                  peak_out  <= tot_peak;
                  res_valid <= 1'b1;
               end
               default: begin
                  xcnt_out  <= tot_xcnt;
                  res_valid <= 1'b1;
               end
            endcase
         end else if (sq_done && mon_en) begin
            pwr_out   <= PWR_W'(sq_root);
            res_valid <= 1'b1;
         end
      end
   end

   // R11
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mon_en) |-> !res_valid);

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable({pwr_out, peak_out, xcnt_out}));

endmodule

// File: tb/sim_sig_power_monitor.sv
module sim_sig_power_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 14;
   localparam int NV = 13;

   typedef struct packed {
      logic [1:0] mode;
      logic       msel;
      logic       cx;
      int         per;
      int         a;
      int         b;
      int         s;
      int         thr;
      int         expv;
      int         lat;
   } vec_t;

   // mode, ms_sel, cplx, period, ampA, ampB, spike@5, thresh, expected, strobe cycle
   localparam vec_t TBL [NV] = '{
      '{2'b00, 1'b1, 1'b0, 256,  100,   77,   100,   0,   10000,  256},
      '{2'b00, 1'b1, 1'b0, 128,  100,    0,  1000,   0,   17734,  128},
      '{2'b00, 1'b1, 1'b1, 256,  300,  400,   300,   0,  250000,  256},
      '{2'b00, 1'b1, 1'b0, 200,   50,    0,    50,   0,  500000,  200},
      '{2'b00, 1'b1, 1'b0, 200,  100,    0,   100,   0, 1048575,  200},
      '{2'b00, 1'b0, 1'b0, 256,  100,    0,   100,   0,     100,  271},
      '{2'b00, 1'b0, 1'b0, 128,  100,    0,  1000,   0,     133,  143},
      '{2'b00, 1'b0, 1'b1, 128, 3000, 4000,  3000,   0,    5000,  143},
      '{2'b01, 1'b0, 1'b0, 128,  100,    0, -2500,   0,    2500,  128},
      '{2'b01, 1'b0, 1'b0, 128,  100,    0, -8192,   0,    8191,  128},
      '{2'b10, 1'b0, 1'b0, 128,  100,    0,    50, 100,     127,  128},
      '{2'b11, 1'b0, 1'b0, 128,  100,    0,  -200, 101,       1,  128},
      '{2'b00, 1'b1, 1'b0,  10,  100,    0,  1000,   0,   17734,  128}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_en = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic        ms_sel = 1'b0;
   logic        cplx_en = 1'b0;
   logic [23:0] win_len = 24'd64;
   logic [12:0] thresh = '0;
   logic [DW-1:0] samp_a = '0;
   logic [DW-1:0] samp_b = '0;
   logic [19:0] pwr_out;
   logic [12:0] peak_out, xcnt_out;
   logic        res_valid;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sig_power_monitor u0 (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .mode_sel(mode_sel),
      .ms_sel(ms_sel), .cplx_en(cplx_en), .win_len(win_len), .thresh(thresh),
      .samp_a(samp_a), .samp_b(samp_b), .pwr_out(pwr_out), .peak_out(peak_out),
      .xcnt_out(xcnt_out), .res_valid(res_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic drive(input int j, input int amp, input int bamp, input int spk);
      int va, vb;
      va = (j == 5) ? spk : ((j % 2 == 1) ? amp : -amp);
      vb = (j % 2 == 1) ? -bamp : bamp;
      samp_a = va[DW-1:0];
      samp_b = vb[DW-1:0];
   endtask

   task automatic run_vec(input vec_t v);
      int got, lat;
      logic [19:0] p0;
      logic [12:0] k0, x0;
      string tag;
      @(negedge clk);
      mon_en = 1'b0;
      @(negedge clk);
      p0 = pwr_out; k0 = peak_out; x0 = xcnt_out;
      mode_sel = v.mode; ms_sel = v.msel; cplx_en = v.cx;
      win_len = v.per[23:0]; thresh = v.thr[12:0];
      mon_en = 1'b1;
      drive(0, v.a, v.b, v.s);
      got = 0; lat = 0;
      for (int k = 1; k <= v.lat + 20 && got == 0; k++) begin
         @(negedge clk);
         if (res_valid) begin
            got = 1; lat = k;
         end else begin
            drive(k, v.a, v.b, v.s);
         end
      end
      // R2: strobe arrives at the expected cycle (R4 adds 15 for the root)
      check(got == 1, "R2 strobe seen", got, 1);
      check(lat == v.lat, v.msel || v.mode != 2'b00 ? "R2 strobe cycle" : "R4 root strobe cycle", lat, v.lat);
      if (v.mode == 2'b00) begin
         tag = v.cx ? "R5 complex power" : (v.msel ? "R3 mean-square" : "R4 rms");
         check(int'(pwr_out) == v.expv, tag, int'(pwr_out), v.expv);
         check(peak_out == k0 && xcnt_out == x0, "R10 others held", int'(peak_out), int'(k0));
      end else if (v.mode == 2'b01) begin
         check(int'(peak_out) == v.expv, "R6 peak", int'(peak_out), v.expv);
         check(pwr_out == p0 && xcnt_out == x0, "R10 others held", int'(pwr_out), int'(p0));
      end else begin
         check(int'(xcnt_out) == v.expv, "R7 crossing count", int'(xcnt_out), v.expv);
         check(pwr_out == p0 && peak_out == k0, "R10 others held", int'(pwr_out), int'(p0));
      end
      @(negedge clk);
      check(res_valid == 1'b0, "R11 single-cycle strobe", int'(res_valid), 0);
   endtask

   // R9: change mode (or complex bit) after 60 samples holding a spike
   task automatic restart_case(input bit use_cx);
      int got, lat, j;
      @(negedge clk);
      mon_en = 1'b0;
      @(negedge clk);
      mode_sel = 2'b00; ms_sel = 1'b1; cplx_en = 1'b0; win_len = 24'd128; thresh = '0;
      mon_en = 1'b1;
      drive(0, 100, 200, 4000);
      got = 0; lat = 0;
      for (int k = 1; k <= 260 && got == 0; k++) begin
         @(negedge clk);
         if (res_valid) begin
            got = 1; lat = k;
         end else begin
            if (k == 60) begin
               if (use_cx) cplx_en = 1'b1;
               else mode_sel = 2'b01;
            end
            j = k;
            drive(j, 100, 200, 4000);
         end
      end
      check(lat == 188, "R9 restart strobe cycle", lat, 188);
      if (use_cx) check(int'(pwr_out) == 50000, "R9 complex restart value", int'(pwr_out), 50000);
      else check(int'(peak_out) == 100, "R9 mode restart peak", int'(peak_out), 100);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int nv;
      logic [19:0] p0;
      logic [12:0] k0, x0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(pwr_out == '0 && peak_out == '0 && xcnt_out == '0, "R1 outputs in reset", int'(pwr_out), 0);
      check(res_valid == 1'b0, "R1 strobe in reset", int'(res_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pwr_out == '0 && peak_out == '0 && xcnt_out == '0, "R1 outputs after reset", int'(pwr_out), 0);
      check(res_valid == 1'b0, "R1 strobe after reset", int'(res_valid), 0);

      for (int i = 0; i < NV; i++) run_vec(TBL[i]);

      // R8: disabled monitor stays silent and holds outputs
      @(negedge clk);
      mon_en = 1'b0; win_len = 24'd128; mode_sel = 2'b01;
      p0 = pwr_out; k0 = peak_out; x0 = xcnt_out;
      nv = 0;
      for (int k = 0; k < 300; k++) begin
         drive(k, 3000, 3000, -8000);
         if (k == 150) mode_sel = 2'b10;
         @(negedge clk);
         if (res_valid) nv++;
      end
      check(nv == 0, "R8 no strobe while disabled", nv, 0);
      check(pwr_out == p0 && peak_out == k0 && xcnt_out == x0, "R8 outputs held while disabled",
            int'(peak_out), int'(k0));

      restart_case(1'b0);
      restart_case(1'b1);

      // R7: count saturation over a long window, every sample hits threshold 0
      run_vec('{2'b10, 1'b0, 1'b0, 10000, 1, 0, 1, 0, 8191, 10000});

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule